// File: doc/BRIEF.md
# UART Oversample Tick Generator

This block derives the timing pulses for a UART from the system clock. A small prescaler divides the clock by a fixed ratio. By default the ratio is 2, and a select bit gives an alternative ratio of 3. The prescaler steps a reload down-counter. Each time that counter passes zero, the block emits a one-cycle oversample tick and reloads. Every sixteenth oversample tick also raises a bit tick in the same cycle. The serial shifter uses the bit tick to time whole bits and the oversample tick to sample within a bit.

Software sees the block as a few register fields, which arrive here as plain inputs: a run bit, a prescaler select, a fractional-mode enable, and a reload value with its write strobe. The generator runs only from the integer path, so the fractional enable has no effect. For a divide-by-2 prescaler, software programs the reload as (clk / (16 * baud)) / 2 - 1. The intended sequence is to clear the run bit, write the reload and the prescaler select, then set the run bit again.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset both tick outputs are low, the stored reload value is 0 and the stored prescaler select is 0 (divide by 2).
- R2: While the run input is sampled low, the prescaler and the counter are held and neither tick output is asserted in the following cycle.
- R3: With select 0, the prescaler divides by 2. If run is first sampled high at clock edge E0, the oversample tick is high after edges E(n-1), E(2n-1), and so on, where n = 2 * (reload + 1).
- R4: With select 1, the prescaler divides by 3, giving n = 3 * (reload + 1) with the same phase rule as R3.
- R5: A reload value of 0 with select 0 gives one oversample tick every 2 clock cycles.
- R6: The bit tick is high exactly with the 16th, 32nd, ... oversample tick after run rises, and never without an oversample tick.
- R7: A reload write strobe or a change of the prescaler select has no effect while run is high. Both are captured only in cycles where run is low, and the values held in the cycle before run rises apply.
- R8: The fractional-mode enable has no effect on tick timing. The integer path is always used.
- R9: Restarting after a stop begins a fresh period and a fresh 16-tick count from the stored reload value.
- R10: Each oversample tick lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run bit; low holds the generator |
| prescSel | input | 1 | Prescaler select: 0 divides by 2, 1 divides by 3 |
| fracEn | input | 1 | Fractional-mode enable, treated as integer mode |
| reloadWr | input | 1 | Write strobe for the reload value |
| reloadIn | input | RELOAD_W | Reload value to store |
| ovsTick | output | 1 | One-cycle oversample tick |
| bitTick | output | 1 | One-cycle bit tick, every 16th oversample tick |

## Verification
The bit tick and the oversample tick must land in the same cycle. A run of 32 ticks at the shortest period checks that the 16th and 32nd oversample ticks carry the bit tick and that no other tick does. A second coincidence is a reload write or select change arriving while the counter is mid-period. The bench drives both during a run and checks that the tick times stay those of the earlier settings, both for that run and for a later restart with no new write.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic hold;      // generator stopped: hold/load counters
    logic step;      // prescaler expired this cycle
    logic wrAccept;  // reload write taken this cycle
  } bgStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/baud_tick_ctrl.sv
module baud_tick_ctrl
  import baud_tick_pkg::*;
#(
  parameter int PRESC_LO = 2,
  parameter int PRESC_HI = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      runEn,
  input  logic      prescSel,
  input  logic      fracEn,
  input  logic      reloadWr,
  output bgStrobe_t strobes
);

  localparam int PRESC_MAX = maxOf(PRESC_LO, PRESC_HI);
  localparam int PW = (PRESC_MAX > 2) ? $clog2(PRESC_MAX) : 1;
  localparam logic [PW-1:0] LIM_LO = PW'(PRESC_LO - 1);
  localparam logic [PW-1:0] LIM_HI = PW'(PRESC_HI - 1);

  logic          selQ;
  logic [PW-1:0] prescCnt;
  logic [PW-1:0] prescLim;
  logic          prescHit;

  // the integer path is always taken; the fractional enable is not consulted
  logic unusedFrac;
  assign unusedFrac = fracEn;

  // select captured only while stopped
  always_ff @(posedge clk) begin
    if (!rstN) selQ <= 1'b0;
    else if (!runEn) selQ <= prescSel;
  end

  generate
    if (PRESC_LO == PRESC_HI) begin : g_fixedDiv
      assign prescLim = LIM_LO;
    end else begin : g_selDiv
      assign prescLim = selQ ? LIM_HI : LIM_LO;
    end
  endgenerate

  assign prescHit = (prescCnt == prescLim);

  always_ff @(posedge clk) begin
    if (!rstN || !runEn) prescCnt <= '0;
    else if (prescHit) prescCnt <= '0;
    else prescCnt <= prescCnt + 1'b1;
  end

  always_comb begin
    strobes.hold     = !runEn;
    strobes.step     = runEn && prescHit;
    strobes.wrAccept = reloadWr && !runEn;
  end

endmodule

// File: rtl/baud_tick_dp.sv
module baud_tick_dp
  import baud_tick_pkg::*;
#(
  parameter int RELOAD_W  = 13,
  parameter int OVS_RATIO = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  bgStrobe_t           strobes,
  input  logic [RELOAD_W-1:0] reloadIn,
  output logic                ovsTick,
  output logic                bitTick
);

  localparam int OW = (OVS_RATIO > 2) ? $clog2(OVS_RATIO) : 1;
  localparam logic [OW-1:0] OVS_LAST = OW'(OVS_RATIO - 1);

  logic [RELOAD_W-1:0] reloadQ;
  logic [RELOAD_W-1:0] downCnt;
  logic [OW-1:0]       ovsCnt;
  logic                wrap;

  assign wrap = strobes.step && (downCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) reloadQ <= '0;
    else if (strobes.wrAccept) reloadQ <= reloadIn;
  end

  // counter follows the reload while stopped so that run starts from it
  always_ff @(posedge clk) begin
    if (!rstN) downCnt <= '0;
    else if (strobes.hold) downCnt <= strobes.wrAccept ? reloadIn : reloadQ;
    else if (wrap) downCnt <= reloadQ;
    else if (strobes.step) downCnt <= downCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.hold) ovsCnt <= '0;
    else if (wrap) ovsCnt <= (ovsCnt == OVS_LAST) ? '0 : ovsCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovsTick <= 1'b0;
      bitTick <= 1'b0;
    end else begin
      ovsTick <= wrap;
      bitTick <= wrap && (ovsCnt == OVS_LAST);
    end
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int RELOAD_W  = 13,
  parameter int PRESC_LO  = 2,
  parameter int PRESC_HI  = 3,
  parameter int OVS_RATIO = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runEn,
  input  logic                prescSel,
  input  logic                fracEn,
  input  logic                reloadWr,
  input  logic [RELOAD_W-1:0] reloadIn,
  output logic                ovsTick,
  output logic                bitTick
);

  bgStrobe_t strobes;

  baud_tick_ctrl #(.PRESC_LO(PRESC_LO), .PRESC_HI(PRESC_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .prescSel(prescSel),
    .fracEn(fracEn), .reloadWr(reloadWr), .strobes(strobes)
  );

  baud_tick_dp #(.RELOAD_W(RELOAD_W), .OVS_RATIO(OVS_RATIO)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reloadIn(reloadIn),
    .ovsTick(ovsTick), .bitTick(bitTick)
  );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int RELOAD_W  = 13,
  parameter int OVS_RATIO = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                runEn,
  input logic                ovsTick,
  input logic                bitTick,
  input logic [RELOAD_W-1:0] reloadQ,
  input logic                selQ
);

  localparam int CW = (OVS_RATIO > 2) ? $clog2(OVS_RATIO) : 1;
  logic [CW-1:0] seenCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !runEn) seenCnt <= '0;
    else if (ovsTick) seenCnt <= (seenCnt == CW'(OVS_RATIO - 1)) ? '0 : seenCnt + 1'b1;
  end

  AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !$past(runEn) |-> (!ovsTick && !bitTick)); // R2
  AST_BIT_NEEDS_OVS: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> ovsTick); // R6
  AST_BIT_ON_SIXTEENTH: assert property (@(posedge clk) disable iff (!rstN)
    ovsTick |-> (bitTick == (seenCnt == CW'(OVS_RATIO - 1)))); // R6
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ovsTick |=> !ovsTick); // R10
  AST_RELOAD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $past(runEn) |-> $stable(reloadQ)); // R7
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $past(runEn) |-> $stable(selQ)); // R7

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.RELOAD_W(RELOAD_W), .OVS_RATIO(OVS_RATIO)) u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .ovsTick(ovsTick), .bitTick(bitTick),
  .reloadQ(u_dp.reloadQ), .selQ(u_ctrl.selQ)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;

  localparam int RW = 13;

  typedef struct {
    int    cyc;
    bit    isBit;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic prescSel = 1'b0;
  logic fracEn = 1'b0;
  logic reloadWr = 1'b0;
  logic [RW-1:0] reloadIn = '0;
  logic ovsTick, bitTick;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  baud_tick_gen #(.RELOAD_W(RW)) u_baud_tick_gen (
    .clk(clk), .rstN(rstN), .runEn(runEn), .prescSel(prescSel), .fracEn(fracEn),
    .reloadWr(reloadWr), .reloadIn(reloadIn), .ovsTick(ovsTick), .bitTick(bitTick)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: every observed tick is matched against the scoreboard
  always @(negedge clk) begin
    if (rstN && ovsTick) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R2 R10: unexpected tick at cycle %0d bit=%0b, expected none", cyc, bitTick);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (e.cyc != cyc || e.isBit != bitTick) begin
          bad++;
          $display("FAIL %s: tick at cycle %0d bit=%0b, expected cycle %0d bit=%0b",
                   e.tag, cyc, bitTick, e.cyc, e.isBit);
        end
      end
    end else if (rstN && bitTick) begin
      total++; bad++;
      $display("FAIL R6: bit tick without oversample tick at cycle %0d, expected none", cyc);
    end
  end

  task automatic checkQuiet(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      total++;
      if (ovsTick || bitTick) begin
        bad++;
        $display("FAIL R2: stopped outputs ovs=%0b bit=%0b, expected 0 0", ovsTick, bitTick);
      end
    end
  endtask

  task automatic runPhase(input int rel, input bit sel, input bit frac, input bit doWrite,
                          input int nTicks, input bit disturb, input string tag);
    int per, base;
    @(negedge clk); #1;
    prescSel = sel;
    fracEn = frac;
    if (doWrite) begin
      reloadIn = RW'(rel);
      reloadWr = 1'b1;
    end
    @(negedge clk); #1;
    reloadWr = 1'b0;
    runEn = 1'b1;
    base = cyc;
    per = (sel ? 3 : 2) * (rel + 1);
    for (int j = 1; j <= nTicks; j++) begin
      expItem_t e;
      e.cyc = base + per * j;
      e.isBit = (j % 16 == 0);
      e.tag = tag;
      expQ.push_back(e);
    end
    if (disturb) begin
      repeat (3) @(negedge clk);
      #1;
      reloadIn = RW'(7);
      reloadWr = 1'b1;
      prescSel = !sel;
      @(negedge clk); #1;
      reloadWr = 1'b0;
    end
    while (expQ.size() != 0) begin
      @(negedge clk); #1;
    end
    runEn = 1'b0;
    prescSel = sel;
    checkQuiet(6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (ovsTick !== 1'b0 || bitTick !== 1'b0) begin
      bad++;
      $display("FAIL R1: outputs in reset ovs=%0b bit=%0b, expected 0 0", ovsTick, bitTick);
    end
    #1 rstN = 1'b1;
    checkQuiet(4); // R2 stopped after reset
    // R1 R5 R6: reset reload 0, shortest period, bit tick on 16th and 32nd
    runPhase(0, 1'b0, 1'b0, 1'b0, 32, 1'b0, "R1 R5 R6");
    // R3: divide by 2 with larger reload
    runPhase(5, 1'b0, 1'b0, 1'b1, 4, 1'b0, "R3");
    // R4: divide by 3
    runPhase(2, 1'b1, 1'b0, 1'b1, 5, 1'b0, "R4");
    // R8: fractional enable set, same integer timing
    runPhase(5, 1'b0, 1'b1, 1'b1, 4, 1'b0, "R8");
    // R7: write and select change while running are ignored
    runPhase(3, 1'b0, 1'b0, 1'b1, 4, 1'b1, "R7");
    // R7 R9: restart without writing keeps old reload, fresh phase
    runPhase(3, 1'b0, 1'b0, 1'b0, 18, 1'b0, "R7 R9");
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R3: %0d ticks missing, expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R3: watchdog expired with %0d ticks pending, expected 0", expQ.size());
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule